// File: doc/BRIEF.md
# Four-Lane Streaming 5x5 Gaussian Smoother

This block smooths a grayscale image that arrives as a raster stream of 32-bit words. Each word carries four adjacent 8-bit pixels. For every word position it produces one output word of four smoothed pixels. Each output pixel is the 5x5 binomial-weighted average of its neighbourhood. The four outputs of a word share one window that is five rows tall and eight pixel columns wide. That window is built from column sums of the current input word and four cached image lines.

Each cached line lives in its own memory, and each memory word holds four pixels. Line storage therefore costs the same bits as a one-pixel-per-clock design. The weighting uses only shifts and adds. Normalisation is a rounded right shift by eight. Pixels outside the picture count as black. After the last input line the block makes two black lines of its own to finish the bottom output rows. The input side uses a valid/ready handshake. The output side flags the first word of a frame, the last word of each line and the last word of the frame.

Top module: `quad_gauss_smoother`

## Requirements
- R1: Output lane i, held in bits [8i+7:8i] of `out_data`, is the smoothed pixel at column 4c+i of the image, where c is the output word index within its line. The same lane order applies to `in_data`.
- R2: Each output pixel equals (S + 128) >> 8. S is the sum over the 5x5 neighbourhood of pixel times w(dy)*w(dx), with w = 1, 4, 6, 4, 1 from top to bottom and from left to right.
- R3: Any neighbourhood position above, below, left of or right of the image contributes 0 to S.
- R4: Output row r is produced while input row r+2 is consumed. The first output word of a frame appears one clock after the edge that accepts word 1 of input row 2.
- R5: `in_ready` is low for exactly one cycle after the last word of each line is accepted. After the last word of the frame it stays low for 1 + 2*(IMG_W/4 + 1) cycles, which covers the two generated black lines. Otherwise it is high.
- R6: Each frame yields exactly IMG_H*IMG_W/4 output words in raster order. `out_sof` marks word 0 of row 0, `out_eol` marks word IMG_W/4-1 of every row, and `out_eof` marks the last word of row IMG_H-1. Flags are high only together with `out_valid`.
- R7: Cycles with `in_valid` low do not change any output value. Only handshaked words are consumed.
- R8: While reset is held and just after it is released, `out_valid` and all output flags are 0 and `in_ready` is 1.
- R9: Frames may follow each other back to back. No pixel of a previous frame affects any output of the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_data | input | 32 | Four input pixels, lane 0 leftmost |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Four smoothed pixels, lane 0 leftmost |
| out_sof | output | 1 | First output word of a frame |
| out_eol | output | 1 | Last output word of a line |
| out_eof | output | 1 | Last output word of a frame |

## Verification
The bench drives four frames back to back.

- A uniform white frame leaves the interior at 255. Its borders show whether missing rows and columns on each side are taken as black.
- A frame of isolated impulses, at two opposite corners and in the middle of words, traces the kernel's weights and the lane order. It also shows any carry-over from the white frame before it.
- A pseudo-random frame exercises rounding across the full value range.
- A diagonal ramp, sent with idle gaps between words, shows that stalls do not disturb the column order.

Handshake timing at line and frame ends and the first-output latency are checked against their cycle counts.

// File: rtl/gs_pkg.sv
package gs_pkg;
  localparam int KTAPS      = 5;
  localparam int HALO       = KTAPS / 2;
  localparam int NORM_SHIFT = 8;

  // 1-4-6-4-1 weighting built from shifts and adds only
  function automatic int unsigned binom5(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d,
                                         input int unsigned e);
    return a + (b << 2) + (c << 2) + (c << 1) + (d << 2) + e;
  endfunction
endpackage

// File: rtl/gs_line_store.sv
module gs_line_store #(
  parameter  int WORD_W = 32,
  parameter  int DEPTH  = 4,
  parameter  int LINES  = 4,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SW     = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic                          clk,
  input  logic                          en,
  input  logic [AW-1:0]                 addr,
  input  logic [SW-1:0]                 wsel,
  input  logic [WORD_W-1:0]             wdata,
  output logic [LINES-1:0][WORD_W-1:0]  rdata
);
  // One read-first memory per cached line; only the selected one is written
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (en) begin
        rd_q <= mem[addr];
        if (wsel == SW'(g)) mem[addr] <= wdata;
      end
    end
    assign rdata[g] = rd_q;
  end
endmodule

// File: rtl/gs_vert.sv
module gs_vert
  import gs_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LANES = 4,
  parameter int VS_W  = PIX_W + 4
) (
  input  logic [KTAPS-1:0][LANES*PIX_W-1:0] rows,
  output logic [LANES-1:0][VS_W-1:0]        vsum
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign vsum[l] = VS_W'(binom5(32'(rows[0][l*PIX_W +: PIX_W]),
                                  32'(rows[1][l*PIX_W +: PIX_W]),
                                  32'(rows[2][l*PIX_W +: PIX_W]),
                                  32'(rows[3][l*PIX_W +: PIX_W]),
                                  32'(rows[4][l*PIX_W +: PIX_W])));
  end
endmodule

// File: rtl/gs_horiz.sv
module gs_horiz
  import gs_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LANES = 4,
  parameter int VS_W  = PIX_W + 4
) (
  input  logic [LANES+2*HALO-1:0][VS_W-1:0] vwin,
  output logic [LANES*PIX_W-1:0]            pix
);
  localparam int unsigned ROUND = 1 << (NORM_SHIFT - 1);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [31:0] hs;
    assign hs = binom5(32'(vwin[l]), 32'(vwin[l+1]), 32'(vwin[l+2]),
                       32'(vwin[l+3]), 32'(vwin[l+4]));
    assign pix[l*PIX_W +: PIX_W] = PIX_W'((hs + ROUND) >> NORM_SHIFT);
  end
endmodule

// File: rtl/quad_gauss_smoother.sv
module quad_gauss_smoother
  import gs_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LANES = 4,
  parameter int IMG_W = 16,
  parameter int IMG_H = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*PIX_W-1:0] in_data,
  output logic                   out_valid,
  output logic [LANES*PIX_W-1:0] out_data,
  output logic                   out_sof,
  output logic                   out_eol,
  output logic                   out_eof
);
  localparam int WORD_W = LANES * PIX_W;
  localparam int WORDS  = IMG_W / LANES;
  localparam int LINES  = KTAPS - 1;
  localparam int VS_W   = PIX_W + 4;
  localparam int CW     = $clog2(WORDS + 1);
  localparam int RW     = $clog2(IMG_H + HALO);
  localparam int AW     = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int SW     = $clog2(LINES);
  localparam int NCOL   = LANES + 2 * HALO;

  // Stage 0: step counters. Column WORDS is a black pad step; rows IMG_H.. are black flush rows
  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic          step;
  logic [WORD_W-1:0] wdata_z;

  assign in_ready = (col_q < CW'(WORDS)) && (row_q < RW'(IMG_H));
  assign step     = in_ready ? in_valid : 1'b1;
  assign wdata_z  = in_ready ? in_data : '0;

  logic [LINES-1:0][WORD_W-1:0] rd;

  gs_line_store #(.WORD_W(WORD_W), .DEPTH(WORDS), .LINES(LINES)) u_lines (
    .clk   (clk),
    .en    (step && (col_q != CW'(WORDS))),
    .addr  (col_q[AW-1:0]),
    .wsel  (row_q[SW-1:0]),
    .wdata (wdata_z),
    .rdata (rd)
  );

  logic              s1_valid;
  logic [CW-1:0]     s1_col;
  logic [RW-1:0]     s1_row;
  logic [WORD_W-1:0] s1_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q    <= '0;
      row_q    <= '0;
      s1_valid <= 1'b0;
      s1_col   <= '0;
      s1_row   <= '0;
      s1_new   <= '0;
    end else begin
      s1_valid <= step;
      if (step) begin
        s1_col <= col_q;
        s1_row <= row_q;
        s1_new <= wdata_z;
        if (col_q == CW'(WORDS)) begin
          col_q <= '0;
          row_q <= (row_q == RW'(IMG_H + HALO - 1)) ? '0 : row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  // Stage 1: assemble the five rows; rows outside the frame are forced black
  logic [KTAPS-1:0][WORD_W-1:0] win_rows;

  always_comb begin
    logic [SW-1:0] idx;
    win_rows[KTAPS-1] = s1_new;
    for (int k = 1; k < KTAPS; k++) begin
      idx = s1_row[SW-1:0] - SW'(k);
      if ((s1_row >= RW'(k)) && ((s1_row - RW'(k)) < RW'(IMG_H)) && (s1_col != CW'(WORDS)))
        win_rows[KTAPS-1-k] = rd[idx];
      else
        win_rows[KTAPS-1-k] = '0;
    end
  end

  logic [LANES-1:0][VS_W-1:0] vnew;
  logic [LANES-1:0][VS_W-1:0] vcur_q;
  logic [HALO-1:0][VS_W-1:0]  vprev_q;
  logic [NCOL-1:0][VS_W-1:0]  vwin;
  logic [WORD_W-1:0]          hpix;

  gs_vert #(.PIX_W(PIX_W), .LANES(LANES), .VS_W(VS_W)) u_vert (
    .rows (win_rows),
    .vsum (vnew)
  );

  for (genvar j = 0; j < NCOL; j++) begin : g_win
    if (j < HALO) begin : g_left
      assign vwin[j] = vprev_q[j];
    end else if (j < HALO + LANES) begin : g_mid
      assign vwin[j] = vcur_q[j-HALO];
    end else begin : g_right
      assign vwin[j] = vnew[j-HALO-LANES];
    end
  end

  gs_horiz #(.PIX_W(PIX_W), .LANES(LANES), .VS_W(VS_W)) u_horiz (
    .vwin (vwin),
    .pix  (hpix)
  );

  logic emit;
  assign emit = s1_valid && (s1_col != '0) && (s1_row >= RW'(HALO));

  always_ff @(posedge clk) begin
    if (rst) begin
      vcur_q    <= '0;
      vprev_q   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      if (s1_valid) begin
        vcur_q <= vnew;
        for (int h = 0; h < HALO; h++) vprev_q[h] <= vcur_q[LANES-HALO+h];
      end
      out_valid <= emit;
      out_sof   <= emit && (s1_row == RW'(HALO)) && (s1_col == CW'(1));
      out_eol   <= emit && (s1_col == CW'(WORDS));
      out_eof   <= emit && (s1_col == CW'(WORDS)) && (s1_row == RW'(IMG_H + HALO - 1));
      if (emit) out_data <= hpix;
    end
  end

  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (rst) out_sof |-> out_valid); // R6
  AST_EOF_ON_EOL: assert property (@(posedge clk) disable iff (rst) out_eof |-> (out_eol && out_valid)); // R6
  AST_PAD_AFTER_LINE: assert property (@(posedge clk) disable iff (rst) (in_valid && in_ready && (col_q == CW'(WORDS - 1))) |=> !in_ready); // R5
  AST_OUT_FROM_STEP: assert property (@(posedge clk) disable iff (rst) out_valid |-> $past(s1_valid)); // R4
endmodule

// File: tb/sim_quad_gauss_smoother.sv
module sim_quad_gauss_smoother;
  localparam int W     = 16;
  localparam int H     = 8;
  localparam int WORDS = W / 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_sof, out_eol, out_eof;

  always #2 clk = ~clk;

  quad_gauss_smoother #(.PIX_W(8), .LANES(4), .IMG_W(W), .IMG_H(H)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eol(out_eol), .out_eof(out_eof)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int acc_r4 = -1;
  int sof_r4 = -1;
  bit done   = 1'b0;
  int img [H][W];
  logic [34:0] expq [$];

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int pix(input int r, input int x);
    if (r < 0 || r >= H || x < 0 || x >= W) return 0;   // R3 black border
    return img[r][x];
  endfunction

  function automatic int ref_px(input int r, input int x);
    int k[5] = '{1, 4, 6, 4, 1};
    int s = 0;
    for (int dy = 0; dy < 5; dy++)
      for (int dx = 0; dx < 5; dx++)
        s += k[dy] * k[dx] * pix(r + dy - 2, x + dx - 2);
    return (s + 128) >> 8;
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (out_sof && sof_r4 < 0) sof_r4 = cyc;
      if (expq.size() == 0) begin
        chk(1'b0, $sformatf("R6 unexpected output word act=%h exp=none", out_data));
      end else begin
        logic [34:0] e;
        e = expq.pop_front();
        chk(out_data == e[31:0],
            $sformatf("R1/R2/R3 pixel word act=%h exp=%h", out_data, e[31:0]));
        chk({out_eof, out_eol, out_sof} == e[34:32],
            $sformatf("R6 flags eof/eol/sof act=%b exp=%b", {out_eof, out_eol, out_sof}, e[34:32]));
      end
    end
  end

  task automatic send(input logic [31:0] w, input int r, input int c, input bit first);
    in_data  = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (first && r == 2 && c == 1) acc_r4 = cyc;
  endtask

  task automatic run_frame(input int pat, input bit gaps, input bit first);
    int seed = 12345 + pat;
    for (int r = 0; r < H; r++)
      for (int x = 0; x < W; x++) begin
        case (pat)
          0: img[r][x] = 255;
          1: img[r][x] = 0;
          2: begin seed = seed * 1103515245 + 12345; img[r][x] = (seed >>> 16) & 255; end
          default: img[r][x] = (x * 13 + r * 29) & 255;
        endcase
      end
    if (pat == 1) begin
      img[0][0] = 255; img[H-1][W-1] = 255; img[3][6] = 200; img[4][8] = 100;
    end
    for (int r = 0; r < H; r++)
      for (int c = 0; c < WORDS; c++) begin
        logic [34:0] e;
        for (int i = 0; i < 4; i++) e[8*i +: 8] = 8'(ref_px(r, 4 * c + i));
        e[32] = (r == 0 && c == 0);
        e[33] = (c == WORDS - 1);
        e[34] = (c == WORDS - 1) && (r == H - 1);
        expq.push_back(e);
      end
    for (int r = 0; r < H; r++)
      for (int c = 0; c < WORDS; c++) begin
        logic [31:0] w;
        for (int i = 0; i < 4; i++) w[8*i +: 8] = 8'(img[r][4 * c + i]);
        send(w, r, c, first);
        if (c == WORDS - 1) begin
          if (r < H - 1) begin
            chk(!in_ready, $sformatf("R5 ready after line end act=%0d exp=0", in_ready));
            @(negedge clk);
            chk(in_ready, $sformatf("R5 ready after pad step act=%0d exp=1", in_ready));
          end else begin
            int n = 0;
            while (!in_ready) begin n++; @(negedge clk); end
            chk(n == 1 + 2 * (WORDS + 1),
                $sformatf("R5 ready low cycles at frame end act=%0d exp=%0d", n, 1 + 2 * (WORDS + 1)));
          end
        end else if (gaps && (c % 2 == 0)) begin
          @(negedge clk);   // R7 idle cycle between words
        end
      end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_sof && !out_eol && !out_eof,
        $sformatf("R8 outputs during reset act=%b exp=0000", {out_valid, out_sof, out_eol, out_eof}));
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, $sformatf("R8 ready after reset act=%0d exp=1", in_ready));
    chk(!out_valid, $sformatf("R8 valid after reset act=%0d exp=0", out_valid));
    run_frame(0, 1'b0, 1'b1);   // flat white: borders
    run_frame(1, 1'b0, 1'b0);   // R9 impulses right after white frame
    run_frame(2, 1'b0, 1'b0);   // pseudo-random: rounding
    run_frame(3, 1'b1, 1'b0);   // R7 ramp with stalls
    for (int t = 0; t < 2000 && expq.size() != 0; t++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(expq.size() == 0, $sformatf("R6 missing output words act=%0d exp=0", expq.size()));
    chk(sof_r4 == acc_r4 + 1, $sformatf("R4 first output cycle act=%0d exp=%0d", sof_r4, acc_r4 + 1));
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule